// File: doc/BRIEF.md
# Display channel mode controller

This block picks the operating mode of a display identification port that can either stream its table continuously under a vertical-sync-derived clock or act as a two-wire bus slave. After reset the port streams (transmit-only). A falling edge on the bus clock moves it to a tentative transition mode. In that mode the bus slave listens for its control byte while the block counts stream-clock pulses.

When the slave's address decoder reports a matching control byte, the block locks into bidirectional mode, and only a reset releases it. When enough stream-clock pulses arrive while the bus clock stays high, the block drops back to streaming and tells the streamer to restart at address zero. Every bus-clock falling edge in transition mode clears the pulse count.

The inputs are a bus clock that is already synchronised, a one-cycle pulse for each stream-clock rising edge, and a one-cycle pulse for a control-byte match. The outputs are the mode code, an enable for the streamer, an enable for the bus slave and a restart pulse for the streamer.

Top module: `ddc_mode_ctrl`

## Requirements
- R1: During and directly after reset, `mode` is 2'b00 (streaming), `stream_en` is 1, `slave_en` is 0 and `stream_restart` is 0.
- R2: In streaming mode, a high-to-low change of `scl_sync` makes `mode` 2'b01 (transition) one clock later, with `stream_en` 0, `slave_en` 1 and the pulse count at zero.
- R3: In transition mode, every high-to-low change of `scl_sync` clears the pulse count, so a full `TIMEOUT` further pulses are needed before the block leaves.
- R4: In transition mode with `scl_sync` high, the `TIMEOUT`-th counted `vclk_rise` pulse (default 128) returns `mode` to 2'b00 on the next clock. `stream_restart` is high for exactly that one cycle.
- R5: A `vclk_rise` pulse that arrives while `scl_sync` is low is not counted.
- R6: A `ctrl_match` pulse in transition mode sets `mode` to 2'b10 (bidirectional) on the next clock, with `stream_en` 0 and `slave_en` 1. It takes priority over a timeout or a falling edge in the same cycle, and `stream_restart` stays 0.
- R7: Once `mode` is 2'b10, it stays 2'b10 whatever arrives on `vclk_rise`, `scl_sync` or `ctrl_match`, until reset.
- R8: In streaming mode, `ctrl_match`, `vclk_rise` and rising edges of `scl_sync` leave `mode` at 2'b00.
- R9: After `TIMEOUT`-1 counted pulses, the block is still in transition mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset (the power-on condition) |
| scl_sync | input | 1 | Synchronised bus clock level |
| vclk_rise | input | 1 | One-cycle pulse for each stream-clock rising edge |
| ctrl_match | input | 1 | One-cycle pulse when the slave decodes its control byte |
| mode | output | 2 | 00 streaming, 01 transition, 10 bidirectional |
| stream_en | output | 1 | Streamer may drive the data line |
| slave_en | output | 1 | Bus slave owns the data line |
| stream_restart | output | 1 | One-cycle pulse telling the streamer to restart at address zero |

## Verification
The embedded properties check on every cycle that the following hold:
- The bidirectional lock holds.
- Streaming is left only on a bus-clock falling edge.
- A falling edge in transition mode clears the count.
- The count never passes the timeout.
- The restart pulse occurs only on a return from transition mode.

The exact pulse number at which the timeout fires can only be shown by the bench's swept scenarios: one pulse short versus exactly at the limit, after a mid-count falling edge, and with pulses arriving while the bus clock is low. The same holds for priority when a match and a timeout arrive in the same cycle.

// File: rtl/ddc_mode_ctrl.sv
module ddc_mode_ctrl #(
  parameter int TIMEOUT = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_sync,
  input  logic       vclk_rise,
  input  logic       ctrl_match,
  output logic [1:0] mode,
  output logic       stream_en,
  output logic       slave_en,
  output logic       stream_restart
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [1:0] M_TX = 2'b00, M_TR = 2'b01, M_BI = 2'b10;

  logic          scl_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_inc;
  logic          fall;
  logic          count_en;

  assign fall     = scl_q & ~scl_sync;
  assign count_en = vclk_rise & scl_sync;
  assign cnt_inc  = (cnt == CMAX) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q          <= 1'b1;
      mode           <= M_TX;
      cnt            <= '0;
      stream_restart <= 1'b0;
    end else begin
      scl_q          <= scl_sync;
      stream_restart <= 1'b0;
      unique case (mode)
        M_TX: if (fall) begin
          mode <= M_TR;
          cnt  <= '0;
        end
        M_TR: begin
          if (ctrl_match) begin
            mode <= M_BI;
          end else if (fall) begin
            cnt <= '0;
          end else if (count_en) begin
            cnt <= cnt_inc;
            if (cnt_inc == LIMIT) begin
              mode           <= M_TX;
              stream_restart <= 1'b1;
            end
          end
        end
        default: mode <= M_BI;
      endcase
    end
  end

  assign stream_en = (mode == M_TX);
  assign slave_en  = (mode != M_TX);

  // R7
  bidir_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_BI |=> mode == M_BI);

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TX && !fall) |=> mode == M_TX);

  // R2
  tx_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TX && fall) |=> (mode == M_TR && cnt == '0));

  // R3
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TR && fall && !ctrl_match) |=> cnt == '0);

  // R4
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  // R4
  restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream_restart) |-> (mode == M_TX && $past(mode) == M_TR));
endmodule

// File: tb/test_ddc_mode_ctrl.sv
module test_ddc_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 128;

  logic clk = 0, rst_n = 0, scl = 1, vr = 0, cm = 0;
  logic [1:0] mode;
  logic stream_en, slave_en, restart;
  int runs = 0, fails = 0;
  bit done = 0;

  ddc_mode_ctrl #(.TIMEOUT(TO)) i_ddc_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_sync(scl), .vclk_rise(vr), .ctrl_match(cm),
    .mode(mode), .stream_en(stream_en), .slave_en(slave_en), .stream_restart(restart));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic s, input logic v, input logic c);
    @(negedge clk);
    scl = s; vr = v; cm = c;
    @(posedge clk);
    #1;
    vr = 0; cm = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 0);
  endtask

  task automatic chk(input string req, input logic [1:0] em, input logic er);
    runs++;
    if (mode !== em || restart !== er || stream_en !== (em == 2'b00) || slave_en !== (em != 2'b00)) begin
      fails++;
      $display("FAIL %s: mode=%b restart=%b sen=%b slv=%b expected mode=%b restart=%b",
               req, mode, restart, stream_en, slave_en, em, er);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; scl = 1; vr = 0; cm = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic enter_tr();
    step(0, 0, 0);
    step(1, 0, 0);
  endtask

  initial begin
    do_reset();
    // R1
    chk("R1", 2'b00, 0);
    // R8: match, pulses and rising edges in streaming mode
    step(1, 0, 1); chk("R8", 2'b00, 0);
    pulses(300);   chk("R8", 2'b00, 0);
    // R2
    step(0, 0, 0); chk("R2", 2'b01, 0);
    step(1, 0, 0); chk("R2", 2'b01, 0);

    // R9/R4 sweep around the limit
    for (int n = TO - 3; n <= TO; n++) begin
      do_reset();
      enter_tr();
      pulses(n);
      if (n < TO) chk("R9", 2'b01, 0);
      else        chk("R4", 2'b00, 1);
    end
    step(1, 0, 0); chk("R4", 2'b00, 0);
    // R4: streaming again, recovery repeats
    enter_tr(); pulses(TO - 1); chk("R9", 2'b01, 0);
    pulses(1); chk("R4", 2'b00, 1);

    // R3: falling edge at several points clears the count
    for (int k = 1; k < TO; k += 37) begin
      do_reset();
      enter_tr();
      pulses(k);
      enter_tr();
      pulses(TO - 1); chk("R3", 2'b01, 0);
      pulses(1);      chk("R3", 2'b00, 1);
    end

    // R5: pulses with DSCL low are not counted
    do_reset();
    step(0, 0, 0);
    for (int i = 0; i < 200; i++) step(0, 1, 0);
    chk("R5", 2'b01, 0);
    step(1, 0, 0);
    pulses(TO - 1); chk("R5", 2'b01, 0);
    pulses(1);      chk("R5", 2'b00, 1);

    // R6: match with a same-cycle timeout
    do_reset();
    enter_tr(); pulses(TO - 1);
    step(1, 1, 1); chk("R6", 2'b10, 0);
    // R6: match with a same-cycle falling edge
    do_reset();
    enter_tr();
    step(0, 0, 1); chk("R6", 2'b10, 0);

    // R7: lock holds
    pulses(2 * TO); chk("R7", 2'b10, 0);
    for (int i = 0; i < 20; i++) begin step(0, 1, 0); step(1, 1, 1); end
    chk("R7", 2'b10, 0);
    do_reset(); chk("R7", 2'b00, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule